// File: doc/BRIEF.md
# Dual-Slot Instruction Word Dispatcher

The dispatcher takes one 32-bit fetched instruction word at a time and turns it into issue beats for downstream execute units. The two top bits of the word pick its format. A word holds either a single long instruction with a 30-bit payload, or two 15-bit short instructions in a left container and a right container. Short pairs run in left-then-right order, in right-then-left order, or together as a parallel pair.

Each beat carries a type tag, the payload (short payloads zero-extended to 30 bits) and a 6-bit opcode group index. A parallel pair normally goes out as one beat with both slots filled. If one container of a parallel pair holds a condition-setting instruction, that container goes out first on its own. The block then waits for the execute flag it produces, and issues the partner or drops it. A saturating counter for each type tag records every slot that is issued.

Top module: `pair_dispatch`

## Requirements
- R1: A word with bits 31:30 = 11 produces exactly one beat with slot 0 tag 0 (long), payload bits 29:0, group bits 29:24, and slot 1 disabled.
- R2: Format 01 issues the left container (bits 29:15) with tag 1, then, in a later accepted beat, the right container (bits 14:0) with tag 2.
- R3: Format 10 issues the right container with tag 2 first, then the left container with tag 1.
- R4: Format 00 with no condition-setting container issues one beat: slot 0 carries the left container with tag 3, and slot 1 is enabled and carries the right container with tag 4.
- R5: The parameter COND_MASK marks condition-setting groups; by default it marks groups 62 and 63. In a format 00 word whose left or right container group is marked (left is checked first), that container issues alone with its plain tag (1 or 2). No beat is valid until flag_valid arrives. If flag_value is 1, the partner then issues with its plain tag. If flag_value is 0, the partner is dropped and the block returns to idle.
- R6: The group index of a short payload is bits 14:9 of its 15-bit container.
- R7: word_ready is high only when no beat or flag wait is pending. Exactly one word is taken per handshake, and word_valid has no effect while the block is busy.
- R8: While iss_valid is high and iss_ready is low, every field of the beat stays unchanged.
- R9: flag_valid has no effect unless the block is waiting for a flag.
- R10: There is one counter per tag. It increases by one for each issued slot that carries that tag. Both slots of a parallel beat count in the same cycle, and a dropped partner is not counted.
- R11: Counters saturate at their all-ones value.
- R12: A synchronous reset clears all counters and leaves the block idle, with word_ready high and iss_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | Instruction word offered |
| word_data | input | 32 | Instruction word |
| word_ready | output | 1 | Block can take a word |
| iss_valid | output | 1 | Issue beat valid |
| iss_ready | input | 1 | Execute side accepts the beat |
| slot0_kind | output | 3 | Slot 0 type tag |
| slot0_payload | output | 30 | Slot 0 payload |
| slot0_group | output | 6 | Slot 0 opcode group |
| slot1_en | output | 1 | Slot 1 carries an instruction |
| slot1_kind | output | 3 | Slot 1 type tag |
| slot1_payload | output | 30 | Slot 1 payload |
| slot1_group | output | 6 | Slot 1 opcode group |
| flag_valid | input | 1 | Execute flag from a condition-setting slot |
| flag_value | input | 1 | Value of the execute flag |
| cnt_long | output | CNT_W | Long slots issued |
| cnt_left | output | CNT_W | Left slots issued |
| cnt_right | output | CNT_W | Right slots issued |
| cnt_lpar | output | CNT_W | Parallel-left slots issued |
| cnt_rpar | output | CNT_W | Parallel-right slots issued |

## Verification
A plain parallel beat increments two counters in the same cycle. With narrow counters, one of them can hit its ceiling while the other still climbs. The bench builds the block with 4-bit counters and runs several hundred words, so saturation and dual increments overlap often. Every cycle it compares each counter against its own model tally. Flag pulses are also driven at random while beats are stalled, to show that only a pending wait reacts to them.

// File: rtl/pair_dispatch_pkg.sv
package pair_dispatch_pkg;
  localparam int WORD_W     = 32;
  localparam int LONG_W     = 30;
  localparam int SHORT_W    = 15;
  localparam int GROUP_W    = 6;
  localparam int NUM_GROUPS = 1 << GROUP_W;
  localparam int NUM_KINDS  = 5;

  typedef enum logic [2:0] {
    KIND_LONG  = 3'd0,
    KIND_LEFT  = 3'd1,
    KIND_RIGHT = 3'd2,
    KIND_LPAR  = 3'd3,
    KIND_RPAR  = 3'd4
  } kind_e;

  typedef enum logic [1:0] {
    FMT_PAR  = 2'b00,
    FMT_LR   = 2'b01,
    FMT_RL   = 2'b10,
    FMT_LONG = 2'b11
  } fmt_e;

  function automatic logic [GROUP_W-1:0] short_group(input logic [SHORT_W-1:0] c);
    return c[SHORT_W-1 -: GROUP_W];
  endfunction

  function automatic logic [GROUP_W-1:0] long_group(input logic [LONG_W-1:0] p);
    return p[LONG_W-1 -: GROUP_W];
  endfunction
endpackage

// File: rtl/pd_split.sv
module pd_split
  import pair_dispatch_pkg::*;
#(
  parameter logic [NUM_GROUPS-1:0] COND_MASK = 64'hC000_0000_0000_0000
) (
  input  logic [WORD_W-1:0]  word,
  output fmt_e               fmt,
  output logic [SHORT_W-1:0] left_c,
  output logic [SHORT_W-1:0] right_c,
  output logic [LONG_W-1:0]  long_pl,
  output logic               left_cond,
  output logic               right_cond
);
  assign fmt        = fmt_e'(word[WORD_W-1 -: 2]);
  assign long_pl    = word[LONG_W-1:0];
  assign left_c     = word[2*SHORT_W-1 -: SHORT_W];
  assign right_c    = word[SHORT_W-1:0];
  assign left_cond  = COND_MASK[short_group(left_c)];
  assign right_cond = COND_MASK[short_group(right_c)];
endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
  import pair_dispatch_pkg::*;
#(
  parameter logic [NUM_GROUPS-1:0] COND_MASK = 64'hC000_0000_0000_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               word_valid,
  input  logic [WORD_W-1:0]  word_data,
  output logic               word_ready,
  output logic               iss_valid,
  input  logic               iss_ready,
  output kind_e              s0_kind,
  output logic [LONG_W-1:0]  s0_pl,
  output logic [GROUP_W-1:0] s0_grp,
  output logic               s1_en,
  output kind_e              s1_kind,
  output logic [LONG_W-1:0]  s1_pl,
  output logic [GROUP_W-1:0] s1_grp,
  input  logic               flag_valid,
  input  logic               flag_value
);
  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND, ST_GATE} st_e;

  st_e                st_q, st_d;
  logic [WORD_W-1:0]  word_q;
  fmt_e               fmt;
  logic [SHORT_W-1:0] left_c, right_c;
  logic [LONG_W-1:0]  long_pl;
  logic               left_cond, right_cond;
  logic               lead_left, plain_par;

  pd_split #(.COND_MASK(COND_MASK)) u_split (
    .word(word_q), .fmt(fmt), .left_c(left_c), .right_c(right_c),
    .long_pl(long_pl), .left_cond(left_cond), .right_cond(right_cond)
  );

  assign lead_left = (fmt == FMT_LR) || ((fmt == FMT_PAR) && left_cond);
  assign plain_par = (fmt == FMT_PAR) && !left_cond && !right_cond;

  always_comb begin
    st_d       = st_q;
    word_ready = 1'b0;
    iss_valid  = 1'b0;
    s0_kind    = KIND_LONG;
    s0_pl      = '0;
    s0_grp     = '0;
    s1_en      = 1'b0;
    s1_kind    = KIND_LONG;
    s1_pl      = '0;
    s1_grp     = '0;
    unique case (st_q)
      ST_IDLE: begin
        word_ready = 1'b1;
        if (word_valid) st_d = ST_FIRST;
      end
      ST_FIRST: begin
        iss_valid = 1'b1;
        if (fmt == FMT_LONG) begin
          s0_kind = KIND_LONG;
          s0_pl   = long_pl;
          s0_grp  = long_group(long_pl);
        end else if (plain_par) begin
          s0_kind = KIND_LPAR;
          s0_pl   = LONG_W'(left_c);
          s0_grp  = short_group(left_c);
          s1_en   = 1'b1;
          s1_kind = KIND_RPAR;
          s1_pl   = LONG_W'(right_c);
          s1_grp  = short_group(right_c);
        end else begin
          s0_kind = lead_left ? KIND_LEFT : KIND_RIGHT;
          s0_pl   = LONG_W'(lead_left ? left_c : right_c);
          s0_grp  = short_group(lead_left ? left_c : right_c);
        end
        if (iss_ready) begin
          if (fmt == FMT_LONG || plain_par) st_d = ST_IDLE;
          else if (fmt == FMT_PAR)          st_d = ST_GATE;
          else                              st_d = ST_SECOND;
        end
      end
      ST_SECOND: begin
        iss_valid = 1'b1;
        s0_kind   = lead_left ? KIND_RIGHT : KIND_LEFT;
        s0_pl     = LONG_W'(lead_left ? right_c : left_c);
        s0_grp    = short_group(lead_left ? right_c : left_c);
        if (iss_ready) st_d = ST_IDLE;
      end
      ST_GATE: begin
        if (flag_valid) st_d = flag_value ? ST_SECOND : ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
    if (st_q == ST_IDLE && word_valid) word_q <= word_data;
  end
endmodule

// File: rtl/pd_tally.sv
module pd_tally
  import pair_dispatch_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            fire,
  input  logic [2:0]                      s0_kind,
  input  logic                            s1_en,
  input  logic [2:0]                      s1_kind,
  output logic [NUM_KINDS-1:0][CNT_W-1:0] counts
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_cnt
    logic bump;
    assign bump = fire && ((s0_kind == 3'(k)) || (s1_en && (s1_kind == 3'(k))));
    always_ff @(posedge clk) begin
      if (rst)                                counts[k] <= '0;
      else if (bump && counts[k] != CNT_MAX)  counts[k] <= counts[k] + 1'b1;
    end
  end
endmodule

// File: rtl/pair_dispatch.sv
module pair_dispatch
  import pair_dispatch_pkg::*;
#(
  parameter int                    CNT_W     = 32,
  parameter logic [NUM_GROUPS-1:0] COND_MASK = 64'hC000_0000_0000_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               word_valid,
  input  logic [31:0]        word_data,
  output logic               word_ready,
  output logic               iss_valid,
  input  logic               iss_ready,
  output logic [2:0]         slot0_kind,
  output logic [29:0]        slot0_payload,
  output logic [5:0]         slot0_group,
  output logic               slot1_en,
  output logic [2:0]         slot1_kind,
  output logic [29:0]        slot1_payload,
  output logic [5:0]         slot1_group,
  input  logic               flag_valid,
  input  logic               flag_value,
  output logic [CNT_W-1:0]   cnt_long,
  output logic [CNT_W-1:0]   cnt_left,
  output logic [CNT_W-1:0]   cnt_right,
  output logic [CNT_W-1:0]   cnt_lpar,
  output logic [CNT_W-1:0]   cnt_rpar
);
  kind_e                          k0, k1;
  logic                           fire;
  logic [NUM_KINDS-1:0][CNT_W-1:0] counts;

  pd_sequencer #(.COND_MASK(COND_MASK)) u_seq (
    .clk(clk), .rst(rst),
    .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
    .iss_valid(iss_valid), .iss_ready(iss_ready),
    .s0_kind(k0), .s0_pl(slot0_payload), .s0_grp(slot0_group),
    .s1_en(slot1_en), .s1_kind(k1), .s1_pl(slot1_payload), .s1_grp(slot1_group),
    .flag_valid(flag_valid), .flag_value(flag_value)
  );

  assign slot0_kind = k0;
  assign slot1_kind = k1;
  assign fire       = iss_valid && iss_ready;

  pd_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst(rst), .fire(fire),
    .s0_kind(slot0_kind), .s1_en(slot1_en), .s1_kind(slot1_kind),
    .counts(counts)
  );

  assign cnt_long  = counts[KIND_LONG];
  assign cnt_left  = counts[KIND_LEFT];
  assign cnt_right = counts[KIND_RIGHT];
  assign cnt_lpar  = counts[KIND_LPAR];
  assign cnt_rpar  = counts[KIND_RPAR];
endmodule

// File: rtl/pd_checker.sv
module pd_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             word_valid,
  input logic             word_ready,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [2:0]       slot0_kind,
  input logic [29:0]      slot0_payload,
  input logic             slot1_en,
  input logic [2:0]       slot1_kind,
  input logic [CNT_W-1:0] cnt_long,
  input logic [CNT_W-1:0] cnt_lpar
);
  logic rst_q;
  logic armed_q;

  always_ff @(posedge clk) begin
    rst_q   <= rst;
    armed_q <= !rst;
  end

  AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(word_ready && iss_valid)); // R7

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (word_valid && word_ready) |=> !word_ready); // R7

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (rst || armed_q !== 1'b1)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(slot0_kind) && $stable(slot0_payload) && $stable(slot1_en))); // R8

  AST_PAIR_TAGS: assert property (@(posedge clk) disable iff (rst)
    slot1_en |-> (iss_valid && slot0_kind == 3'd3 && slot1_kind == 3'd4)); // R4

  AST_LONG_SOLO: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && slot0_kind == 3'd0) |-> !slot1_en); // R1

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst || armed_q !== 1'b1)
    (CNT_W'(cnt_long - $past(cnt_long)) <= CNT_W'(1))); // R10

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst || armed_q !== 1'b1)
    ($past(cnt_lpar) == {CNT_W{1'b1}}) |-> (cnt_lpar == {CNT_W{1'b1}})); // R11

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    (rst_q === 1'b1) |-> (word_ready && !iss_valid && cnt_long == '0)); // R12
endmodule

bind pair_dispatch pd_checker #(.CNT_W(CNT_W)) u_pd_checker (
  .clk(clk), .rst(rst), .word_valid(word_valid), .word_ready(word_ready),
  .iss_valid(iss_valid), .iss_ready(iss_ready),
  .slot0_kind(slot0_kind), .slot0_payload(slot0_payload),
  .slot1_en(slot1_en), .slot1_kind(slot1_kind),
  .cnt_long(cnt_long), .cnt_lpar(cnt_lpar)
);

// File: tb/test_pair_dispatch.sv
module test_pair_dispatch;
  localparam int CW   = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic word_valid, word_ready, iss_valid, iss_ready, slot1_en, flag_valid, flag_value;
  logic [31:0] word_data;
  logic [2:0]  slot0_kind, slot1_kind;
  logic [29:0] slot0_payload, slot1_payload;
  logic [5:0]  slot0_group, slot1_group;
  logic [CW-1:0] cnt_long, cnt_left, cnt_right, cnt_lpar, cnt_rpar;

  pair_dispatch #(.CNT_W(CW)) i_pair_dispatch (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_data(word_data),
    .word_ready(word_ready), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .slot0_kind(slot0_kind), .slot0_payload(slot0_payload), .slot0_group(slot0_group),
    .slot1_en(slot1_en), .slot1_kind(slot1_kind), .slot1_payload(slot1_payload),
    .slot1_group(slot1_group), .flag_valid(flag_valid), .flag_value(flag_value),
    .cnt_long(cnt_long), .cnt_left(cnt_left), .cnt_right(cnt_right),
    .cnt_lpar(cnt_lpar), .cnt_rpar(cnt_rpar)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic        gate;
    logic [2:0]  k0;
    logic [29:0] p0;
    logic [5:0]  g0;
    logic        two;
    logic [2:0]  k1;
    logic [29:0] p1;
    logic [5:0]  g1;
    logic [3:0]  tag;
  } beat_t;

  beat_t q[$];
  int    tally[5];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    acc_last = 0;
  bit    done = 0;
  int    cyc = 0;

  function automatic string rq(int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string r, string what, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  function automatic bit cond_grp(logic [14:0] c);
    return c[14:9] >= 6'd62;
  endfunction

  function automatic beat_t one(logic [2:0] k, logic [29:0] p, logic [5:0] g, int tag);
    beat_t b;
    b = '0;
    b.k0 = k; b.p0 = p; b.g0 = g; b.tag = 4'(tag);
    return b;
  endfunction

  task automatic push_word(logic [31:0] w);
    logic [14:0] lc, rc;
    beat_t b, gt;
    lc = w[29:15];
    rc = w[14:0];
    gt = '0;
    gt.gate = 1'b1;
    case (w[31:30])
      2'b11: q.push_back(one(3'd0, w[29:0], w[29:24], 1));
      2'b01: begin
        q.push_back(one(3'd1, {15'd0, lc}, lc[14:9], 2));
        q.push_back(one(3'd2, {15'd0, rc}, rc[14:9], 2));
      end
      2'b10: begin
        q.push_back(one(3'd2, {15'd0, rc}, rc[14:9], 3));
        q.push_back(one(3'd1, {15'd0, lc}, lc[14:9], 3));
      end
      default: begin
        if (cond_grp(lc)) begin
          q.push_back(one(3'd1, {15'd0, lc}, lc[14:9], 5));
          q.push_back(gt);
          q.push_back(one(3'd2, {15'd0, rc}, rc[14:9], 5));
        end else if (cond_grp(rc)) begin
          q.push_back(one(3'd2, {15'd0, rc}, rc[14:9], 5));
          q.push_back(gt);
          q.push_back(one(3'd1, {15'd0, lc}, lc[14:9], 5));
        end else begin
          b = one(3'd3, {15'd0, lc}, lc[14:9], 4);
          b.two = 1'b1; b.k1 = 3'd4; b.p1 = {15'd0, rc}; b.g1 = rc[14:9];
          q.push_back(b);
        end
      end
    endcase
  endtask

  task automatic bump(int k);
    if (tally[k] < CMAX) tally[k]++;
  endtask

  // Reference model: advance on the inputs of the last edge, then compare
  always @(negedge clk) begin
    bit er, ev, fv_out, held;
    string r, rc;
    er     = (q.size() == 0);
    ev     = (q.size() > 0) && !q[0].gate;
    fv_out = flag_valid && !((q.size() > 0) && q[0].gate);
    held   = ev && !iss_ready && !rst;
    acc_last = 0;
    if (rst) begin
      q.delete();
      foreach (tally[i]) tally[i] = 0;
    end else begin
      if (ev && iss_ready) begin
        bump(int'(q[0].k0));
        if (q[0].two) bump(int'(q[0].k1));
        void'(q.pop_front());
      end else if ((q.size() > 0) && q[0].gate && flag_valid) begin
        void'(q.pop_front());
        if (!flag_value) void'(q.pop_front());
      end
      if (er && word_valid) begin
        push_word(word_data);
        acc_last = 1;
      end
    end
    er = (q.size() == 0);
    ev = (q.size() > 0) && !q[0].gate;
    chk(rst ? "R12" : "R7", "word_ready", word_ready, er);
    chk(fv_out ? "R9" : "R5", "iss_valid", iss_valid, ev);
    if (ev) begin
      r = held ? "R8" : rq(int'(q[0].tag));
      chk(r, "slot0_kind", slot0_kind, q[0].k0);
      chk(r, "slot0_payload", slot0_payload, q[0].p0);
      chk((q[0].k0 == 3'd0) ? "R1" : "R6", "slot0_group", slot0_group, q[0].g0);
      chk(r, "slot1_en", slot1_en, q[0].two);
      if (q[0].two) begin
        chk("R4", "slot1_kind", slot1_kind, q[0].k1);
        chk("R4", "slot1_payload", slot1_payload, q[0].p1);
        chk("R6", "slot1_group", slot1_group, q[0].g1);
      end
    end
    rc = rst ? "R12" : "R10";
    chk((tally[0] == CMAX) ? "R11" : rc, "cnt_long",  cnt_long,  tally[0]);
    chk((tally[1] == CMAX) ? "R11" : rc, "cnt_left",  cnt_left,  tally[1]);
    chk((tally[2] == CMAX) ? "R11" : rc, "cnt_right", cnt_right, tally[2]);
    chk((tally[3] == CMAX) ? "R11" : rc, "cnt_lpar",  cnt_lpar,  tally[3]);
    chk((tally[4] == CMAX) ? "R11" : rc, "cnt_rpar",  cnt_rpar,  tally[4]);
  end

  task automatic knobs();
    iss_ready  = ($urandom % 4) != 0;
    flag_valid = ($urandom % 3) == 0;
    flag_value = $urandom % 2;
  endtask

  task automatic send(logic [31:0] w);
    word_valid = 1'b1;
    word_data  = w;
    do begin
      knobs();
      @(negedge clk);
      #1;
    end while (!acc_last);
    word_valid = 1'b0;
  endtask

  function automatic logic [31:0] mkw(logic [1:0] f, logic [14:0] l, logic [14:0] r);
    return {f, l, r};
  endfunction

  function automatic logic [31:0] rnd_word();
    logic [31:0] w;
    w = $urandom;
    if ($urandom % 3 == 0) w[29:24] = 6'h3E | 6'($urandom % 2);
    if ($urandom % 3 == 0) w[14:9]  = 6'h3E | 6'($urandom % 2);
    return w;
  endfunction

  initial begin
    word_valid = 1'b0; word_data = '0; iss_ready = 1'b0;
    flag_valid = 1'b0; flag_value = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    send(32'hC3A5_1234);                      // R1
    send(mkw(2'b01, 15'h1234, 15'h0567));     // R2
    send(mkw(2'b10, 15'h2AAA, 15'h1555));     // R3
    send(mkw(2'b00, 15'h0101, 15'h0202));     // R4
    send(mkw(2'b00, 15'h7C11, 15'h0333));     // R5 left condition
    send(mkw(2'b00, 15'h0044, 15'h7E22));     // R5 right condition
    send(mkw(2'b00, 15'h7C00, 15'h7E00));     // R5 both marked
    for (int i = 0; i < 200; i++) begin
      send(rnd_word());
      if ($urandom % 4 == 0) begin
        knobs();
        @(negedge clk); #1;
      end
    end
    rst = 1'b1;                               // R12 mid-run reset
    repeat (2) begin knobs(); @(negedge clk); #1; end
    rst = 1'b0;
    for (int i = 0; i < 200; i++) send(rnd_word());
    iss_ready = 1'b1; flag_valid = 1'b1; flag_value = 1'b1;
    repeat (8) @(negedge clk);
    #1 done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule